// File: doc/BRIEF.md
# Host Handshake Status Register Unit

This block builds the one-byte device status that a host polls before it sends a command or fetches a response. The byte gathers the device's condition flags: write in progress, write enable, an active-low wake flag, checksum error, response ready and execution error. The host can read it in two ways. It can issue a memory read while the read pointer sits on the status address, or it can issue a dedicated status command. Neither kind of status read moves the read pointer, so the host can poll the same location over and over.

The block also owns the memory read pointer, forwards array writes except those aimed at the status address, and tracks the device power state. A status read that arrives while the device sleeps or stands by starts a wakeup. Until that wakeup has run its fixed number of cycles, every read returns all ones. In the serial-peripheral bus mode a read is always served. In the two-wire mode a read is served only once the device address has been acknowledged.

Each accepted byte read captures its data into an output register on the request edge. Flag changes after that edge therefore cannot disturb a byte that is being shifted out.

Top module: `hs_status_unit`

## Requirements
- R1: An awake status read returns exec_err_i in bit 7, resp_rdy_i in bit 6, crc_err_i in bit 4, the write-enable flag in bit 1 and wip_i in bit 0. Bits 5, 3 and 2 read 0.
- R2: A memory read (byte_rd_i) with ptr_o equal to STATUS_ADDR (default 16'hFFF0) returns the status byte and leaves ptr_o unchanged. A memory read at any other address returns mem_data_i and advances ptr_o by one, wrapping at the top of the address range. A ptr_load_i in the same cycle takes priority.
- R3: A status command read (stat_cmd_i) returns the status byte and never changes ptr_o.
- R4: With two_wire_i=0, every read request is served the cycle after its edge (rd_valid_o=1), whatever the state of addr_ack_i, wip_i or the other flags.
- R5: An accepted read while pwr_state_o is sleep (2'b01) or standby (2'b10) pulses wake_req_o for one cycle and moves pwr_state_o to waking (2'b11).
- R6: While pwr_state_o is not active (2'b00), an accepted read returns 8'hFF and does not move ptr_o. Waking lasts WAKE_CYC cycles, after which the state is active.
- R7: With two_wire_i=1 and addr_ack_i=0, a read request produces no rd_valid_o, no wakeup and no pointer change.
- R8: rd_data_o holds the value captured at the edge of the last accepted read until the next accepted read, even when the flags change.
- R9: The write-enable flag is set by wen_set_i. It is cleared by wen_clr_i, or when wip_i was 1 at the previous edge and is 0 now. A clear wins over a set. The flag is 0 after reset.
- R10: arr_wr_o follows mem_wr_i, except when ptr_o equals STATUS_ADDR, in which case it is 0 and the status register ignores the write.
- R11: Reset gives pwr_state_o active, ptr_o 0 and rd_valid_o 0. From active, sleep_req_i enters sleep and otherwise standby_req_i enters standby. Outside the active state both requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| two_wire_i | input | 1 | 1 selects the two-wire bus mode, 0 the serial-peripheral mode |
| addr_ack_i | input | 1 | Device address phase acknowledged (two-wire mode) |
| byte_rd_i | input | 1 | Start of a memory-read byte transfer at ptr_o |
| stat_cmd_i | input | 1 | Start of a status-command byte transfer |
| ptr_load_i | input | 1 | Load the read pointer |
| ptr_addr_i | input | AW | Value loaded into the read pointer |
| mem_data_i | input | 8 | Array byte at ptr_o |
| mem_wr_i | input | 1 | Host write at ptr_o |
| wip_i | input | 1 | EEPROM write in progress |
| crc_err_i | input | 1 | Checksum error flag |
| resp_rdy_i | input | 1 | Response ready flag |
| exec_err_i | input | 1 | Execution error flag |
| wen_set_i | input | 1 | Write-enable set strobe |
| wen_clr_i | input | 1 | Write-disable strobe |
| sleep_req_i | input | 1 | Request to enter sleep |
| standby_req_i | input | 1 | Request to enter standby |
| rd_data_o | output | 8 | Byte captured for the current transfer |
| rd_valid_o | output | 1 | rd_data_o was captured at the last edge |
| ptr_o | output | AW | Memory read pointer |
| arr_wr_o | output | 1 | Write forwarded to the array |
| pwr_state_o | output | 2 | 00 active, 01 sleep, 10 standby, 11 waking |
| wake_req_o | output | 1 | One-cycle wakeup request |

## Verification
The random traffic mixes memory reads and status-command reads while pointer loads often land on the status address or just below it. This separates the hold behaviour at the status address from the increment behaviour on either side of it. The flag inputs and the write-enable strobes change every few cycles, so each read checks the bit placement and the hold between reads against a fresh flag pattern. The bench alternates the bus mode in blocks and drops the acknowledge at random, which separates requests that must be served from requests that must be ignored. Rare sleep and standby requests drive reads into the waking window, where all-ones data and the exact wakeup length are checked. Directed cases pin an exact status byte, reads in both low-power states and a run of reads without acknowledge.

// File: rtl/hs_status_pkg.sv
package hs_status_pkg;
  typedef enum logic [1:0] {
    PWR_ACTIVE  = 2'b00,
    PWR_SLEEP   = 2'b01,
    PWR_STANDBY = 2'b10,
    PWR_WAKING  = 2'b11
  } pwr_e;

  localparam int unsigned BIT_EXEC  = 7;
  localparam int unsigned BIT_RRDY  = 6;
  localparam int unsigned BIT_CRC   = 4;
  localparam int unsigned BIT_WAKEN = 2;
  localparam int unsigned BIT_WEN   = 1;
  localparam int unsigned BIT_WIP   = 0;

  function automatic logic [7:0] pack_status(input logic exec, input logic rrdy,
                                             input logic crc, input logic wake_n,
                                             input logic wen, input logic wip);
    logic [7:0] b;
    b            = '0;
    b[BIT_EXEC]  = exec;
    b[BIT_RRDY]  = rrdy;
    b[BIT_CRC]   = crc;
    b[BIT_WAKEN] = wake_n;
    b[BIT_WEN]   = wen;
    b[BIT_WIP]   = wip;
    return b;
  endfunction
endpackage

// File: rtl/hs_wen_flag.sv
module hs_wen_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic wip_i,
  output logic wen_o
);
  logic wip_q;
  logic wip_fall;

  assign wip_fall = wip_q & ~wip_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wip_q <= 1'b0;
      wen_o <= 1'b0;
    end else begin
      wip_q <= wip_i;
      if (clr_i || wip_fall) wen_o <= 1'b0;
      else if (set_i)        wen_o <= 1'b1;
    end
  end
endmodule

// File: rtl/hs_power_fsm.sv
module hs_power_fsm
  import hs_status_pkg::*;
#(
  parameter int unsigned WAKE_CYC = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_req_i,
  input  logic       standby_req_i,
  input  logic       rd_acc_i,
  output pwr_e       state_o,
  output logic       awake_o,
  output logic       wake_req_o
);
  localparam int unsigned CW = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;
  localparam logic [CW-1:0] CNT_INIT = CW'(WAKE_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign awake_o = (state_o == PWR_ACTIVE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o    <= PWR_ACTIVE;
      cnt_q      <= '0;
      wake_req_o <= 1'b0;
    end else begin
      wake_req_o <= 1'b0;
      unique case (state_o)
        PWR_ACTIVE: begin
          if (sleep_req_i)        state_o <= PWR_SLEEP;
          else if (standby_req_i) state_o <= PWR_STANDBY;
        end
        PWR_SLEEP, PWR_STANDBY: begin
          if (rd_acc_i) begin
            state_o    <= PWR_WAKING;
            cnt_q      <= CNT_INIT;
            wake_req_o <= 1'b1;
          end
        end
        PWR_WAKING: begin
          if (cnt_q == '0) state_o <= PWR_ACTIVE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_o <= PWR_ACTIVE;
      endcase
    end
  end
endmodule

// File: rtl/hs_read_port.sv
module hs_read_port #(
  parameter int unsigned    AW          = 16,
  parameter logic [AW-1:0]  STATUS_ADDR = AW'('hFFF0)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_acc_i,
  input  logic          stat_cmd_i,
  input  logic          ptr_load_i,
  input  logic [AW-1:0] ptr_addr_i,
  input  logic          awake_i,
  input  logic [7:0]    status_i,
  input  logic [7:0]    mem_data_i,
  output logic [7:0]    rd_data_o,
  output logic          rd_valid_o,
  output logic [AW-1:0] ptr_o,
  output logic          at_status_o
);
  logic is_stat;

  assign at_status_o = (ptr_o == STATUS_ADDR);
  assign is_stat     = stat_cmd_i | at_status_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
      ptr_o      <= '0;
    end else begin
      rd_valid_o <= rd_acc_i;
      // shadow capture at the transfer start
      if (rd_acc_i) begin
        if (!awake_i)     rd_data_o <= 8'hFF;
        else if (is_stat) rd_data_o <= status_i;
        else              rd_data_o <= mem_data_i;
      end
      if (ptr_load_i)                          ptr_o <= ptr_addr_i;
      else if (rd_acc_i && awake_i && !is_stat) ptr_o <= ptr_o + 1'b1;
    end
  end
endmodule

// File: rtl/hs_status_unit.sv
module hs_status_unit
  import hs_status_pkg::*;
#(
  parameter int unsigned   AW          = 16,
  parameter logic [AW-1:0] STATUS_ADDR = AW'('hFFF0),
  parameter int unsigned   WAKE_CYC    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          two_wire_i,
  input  logic          addr_ack_i,
  input  logic          byte_rd_i,
  input  logic          stat_cmd_i,
  input  logic          ptr_load_i,
  input  logic [AW-1:0] ptr_addr_i,
  input  logic [7:0]    mem_data_i,
  input  logic          mem_wr_i,
  input  logic          wip_i,
  input  logic          crc_err_i,
  input  logic          resp_rdy_i,
  input  logic          exec_err_i,
  input  logic          wen_set_i,
  input  logic          wen_clr_i,
  input  logic          sleep_req_i,
  input  logic          standby_req_i,
  output logic [7:0]    rd_data_o,
  output logic          rd_valid_o,
  output logic [AW-1:0] ptr_o,
  output logic          arr_wr_o,
  output logic [1:0]    pwr_state_o,
  output logic          wake_req_o
);
  logic       rd_acc;
  logic       awake;
  logic       wen_q;
  logic       at_status;
  logic [7:0] status_byte;
  pwr_e       pwr_state;

  // two-wire mode grants the read only after the address ack
  assign rd_acc      = (byte_rd_i | stat_cmd_i) & (~two_wire_i | addr_ack_i);
  assign status_byte = pack_status(exec_err_i, resp_rdy_i, crc_err_i, ~awake, wen_q, wip_i);
  assign arr_wr_o    = mem_wr_i & ~at_status;
  assign pwr_state_o = pwr_state;

  hs_wen_flag u_wen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wen_set_i),
    .clr_i  (wen_clr_i),
    .wip_i  (wip_i),
    .wen_o  (wen_q)
  );

  hs_power_fsm #(.WAKE_CYC(WAKE_CYC)) u_pwr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sleep_req_i   (sleep_req_i),
    .standby_req_i (standby_req_i),
    .rd_acc_i      (rd_acc),
    .state_o       (pwr_state),
    .awake_o       (awake),
    .wake_req_o    (wake_req_o)
  );

  hs_read_port #(.AW(AW), .STATUS_ADDR(STATUS_ADDR)) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_acc_i    (rd_acc),
    .stat_cmd_i  (stat_cmd_i),
    .ptr_load_i  (ptr_load_i),
    .ptr_addr_i  (ptr_addr_i),
    .awake_i     (awake),
    .status_i    (status_byte),
    .mem_data_i  (mem_data_i),
    .rd_data_o   (rd_data_o),
    .rd_valid_o  (rd_valid_o),
    .ptr_o       (ptr_o),
    .at_status_o (at_status)
  );
endmodule

// File: rtl/hs_status_chk.sv
module hs_status_chk #(
  parameter int unsigned   AW          = 16,
  parameter logic [AW-1:0] STATUS_ADDR = AW'('hFFF0)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          two_wire_i,
  input logic          addr_ack_i,
  input logic          byte_rd_i,
  input logic          stat_cmd_i,
  input logic          ptr_load_i,
  input logic          mem_wr_i,
  input logic          wen_clr_i,
  input logic [7:0]    rd_data_o,
  input logic          rd_valid_o,
  input logic [AW-1:0] ptr_o,
  input logic          arr_wr_o,
  input logic [1:0]    pwr_state_o,
  input logic          wake_req_o,
  input logic          wen
);
  logic req, acc;
  assign req = byte_rd_i | stat_cmd_i;
  assign acc = req & (~two_wire_i | addr_ack_i);

  p_stat_reserved_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && stat_cmd_i && pwr_state_o == 2'b00 |=>
      rd_data_o[5] == 1'b0 && rd_data_o[3] == 1'b0 && rd_data_o[2] == 1'b0);

  p_ptr_hold_mem_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && ptr_o == STATUS_ADDR && !ptr_load_i |=> $stable(ptr_o));

  p_ptr_hold_cmd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && stat_cmd_i && !ptr_load_i |=> $stable(ptr_o));

  p_spi_served_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req && !two_wire_i |=> rd_valid_o);

  p_wake_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && (pwr_state_o == 2'b01 || pwr_state_o == 2'b10) |=>
      wake_req_o && pwr_state_o == 2'b11);

  p_ones_asleep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && pwr_state_o != 2'b00 |=> rd_data_o == 8'hFF);

  p_nack_silent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    two_wire_i && !addr_ack_i |=> !rd_valid_o && !wake_req_o);

  p_shadow_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> $stable(rd_data_o));

  p_wen_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wen_clr_i |=> !wen);

  p_status_wr_block_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_i && ptr_o == STATUS_ADDR |-> !arr_wr_o);

  p_waking_exit_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_state_o == 2'b11 |=> pwr_state_o == 2'b11 || pwr_state_o == 2'b00);
endmodule

bind hs_status_unit hs_status_chk #(.AW(AW), .STATUS_ADDR(STATUS_ADDR)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .two_wire_i  (two_wire_i),
  .addr_ack_i  (addr_ack_i),
  .byte_rd_i   (byte_rd_i),
  .stat_cmd_i  (stat_cmd_i),
  .ptr_load_i  (ptr_load_i),
  .mem_wr_i    (mem_wr_i),
  .wen_clr_i   (wen_clr_i),
  .rd_data_o   (rd_data_o),
  .rd_valid_o  (rd_valid_o),
  .ptr_o       (ptr_o),
  .arr_wr_o    (arr_wr_o),
  .pwr_state_o (pwr_state_o),
  .wake_req_o  (wake_req_o),
  .wen         (wen_q)
);

// File: tb/hs_status_unit_bench.sv
`timescale 1ns/1ps
module hs_status_unit_bench;
  localparam int unsigned AW   = 16;
  localparam logic [15:0] SADR = 16'hFFF0;
  localparam int          WCYC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic two_wire, ack, byte_rd, stat_cmd, ptr_load, mem_wr;
  logic [15:0] ptr_addr;
  logic [7:0]  mem_data;
  logic wip, crc, rrdy, exec_e, wset, wclr, slp, stb;
  logic [7:0]  rd_data;
  logic        rd_valid, arr_wr, wake_req;
  logic [15:0] ptr;
  logic [1:0]  pwr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model state
  logic [15:0] m_ptr;
  logic [1:0]  m_st;
  int          m_cnt;
  logic        m_wen, m_wip_prev, m_valid, m_wake;
  logic [7:0]  m_data;

  always #2 clk = ~clk;

  hs_status_unit #(.AW(AW), .STATUS_ADDR(SADR), .WAKE_CYC(WCYC)) u_hs_status_unit (
    .clk_i(clk), .rst_ni(rst_n), .two_wire_i(two_wire), .addr_ack_i(ack),
    .byte_rd_i(byte_rd), .stat_cmd_i(stat_cmd), .ptr_load_i(ptr_load),
    .ptr_addr_i(ptr_addr), .mem_data_i(mem_data), .mem_wr_i(mem_wr),
    .wip_i(wip), .crc_err_i(crc), .resp_rdy_i(rrdy), .exec_err_i(exec_e),
    .wen_set_i(wset), .wen_clr_i(wclr), .sleep_req_i(slp), .standby_req_i(stb),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .ptr_o(ptr), .arr_wr_o(arr_wr),
    .pwr_state_o(pwr), .wake_req_o(wake_req)
  );

  function automatic logic [7:0] exp_status(logic e, logic r, logic c, logic w, logic p);
    return {e, r, 1'b0, c, 1'b0, 1'b0, w, p};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    byte_rd = 0; stat_cmd = 0; ptr_load = 0; mem_wr = 0;
    wset = 0; wclr = 0; slp = 0; stb = 0;
  endtask

  // one clock: update model at the edge, compare at the following negedge
  task automatic step();
    logic acc, is_stat, awake;
    @(posedge clk);
    acc     = (byte_rd | stat_cmd) & (~two_wire | ack);
    awake   = (m_st == 2'b00);
    is_stat = stat_cmd | (m_ptr == SADR);
    m_valid = acc;
    m_wake  = acc && (m_st == 2'b01 || m_st == 2'b10);
    if (acc) m_data = !awake ? 8'hFF : is_stat ? exp_status(exec_e, rrdy, crc, m_wen, wip) : mem_data;
    if (ptr_load) m_ptr = ptr_addr;
    else if (acc && awake && !is_stat) m_ptr = m_ptr + 16'd1;
    case (m_st)
      2'b00: if (slp) m_st = 2'b01; else if (stb) m_st = 2'b10;
      2'b01, 2'b10: if (acc) begin m_st = 2'b11; m_cnt = WCYC - 1; end
      default: if (m_cnt == 0) m_st = 2'b00; else m_cnt--;
    endcase
    if (wclr || (m_wip_prev && !wip)) m_wen = 1'b0;
    else if (wset) m_wen = 1'b1;
    m_wip_prev = wip;
    @(negedge clk);
    chk("R4/R7 rd_valid", {15'd0, rd_valid}, {15'd0, m_valid});
    chk("R1/R2/R6/R8 rd_data", {8'd0, rd_data}, {8'd0, m_data});
    chk("R2/R3 ptr", ptr, m_ptr);
    chk("R5/R6/R11 pwr_state", {14'd0, pwr}, {14'd0, m_st});
    chk("R5 wake_req", {15'd0, wake_req}, {15'd0, m_wake});
  endtask

  task automatic chk_wr();
    #0.5;
    chk("R10 arr_wr", {15'd0, arr_wr}, {15'd0, mem_wr && (m_ptr != SADR)});
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=%h exp=%h", 1'b0, 1'b1);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    two_wire = 0; ack = 0; ptr_addr = '0; mem_data = '0;
    wip = 0; crc = 0; rrdy = 0; exec_e = 0;
    idle_inputs();
    m_ptr = '0; m_st = 2'b00; m_cnt = 0; m_wen = 0; m_wip_prev = 0;
    m_valid = 0; m_wake = 0; m_data = '0;
    #9;
    // reset state, R11
    chk("R11 reset ptr", ptr, 16'h0000);
    chk("R11 reset pwr", {14'd0, pwr}, 16'h0000);
    chk("R11 reset valid", {15'd0, rd_valid}, 16'h0000);
    @(negedge clk); rst_n = 1'b1;

    // R1 exact status byte via status command, R9 set
    wset = 1; step(); idle_inputs();
    wip = 1; crc = 1; exec_e = 1; rrdy = 0; stat_cmd = 1;
    step(); idle_inputs();
    chk("R1 status byte", {8'd0, rd_data}, 16'h0093);
    // R9 clear on wip fall
    wip = 0; step(); stat_cmd = 1; step(); idle_inputs();
    chk("R9 wen cleared on wip fall", {15'd0, rd_data[1]}, 16'h0000);

    // R2 memory read just below status address then at it
    ptr_load = 1; ptr_addr = SADR - 16'd1; step(); idle_inputs();
    byte_rd = 1; mem_data = 8'h5A; step();
    chk("R2 mem byte", {8'd0, rd_data}, 16'h005A);
    chk("R2 ptr at status", ptr, SADR);
    step(); step(); idle_inputs();
    chk("R2 ptr held at status", ptr, SADR);
    mem_wr = 1; chk_wr(); step(); idle_inputs();

    // R5/R6 read during sleep and standby
    slp = 1; step(); idle_inputs();
    stat_cmd = 1; step(); idle_inputs();
    chk("R6 ones in sleep", {8'd0, rd_data}, 16'h00FF);
    chk("R5 waking", {14'd0, pwr}, 16'h0003);
    for (int i = 0; i < WCYC; i++) step();
    chk("R6 active after wake", {14'd0, pwr}, 16'h0000);
    stb = 1; step(); idle_inputs();
    byte_rd = 1; step(); idle_inputs();
    chk("R6 ones in standby", {8'd0, rd_data}, 16'h00FF);
    for (int i = 0; i < WCYC; i++) step();

    // R7 two-wire without ack
    two_wire = 1; ack = 0; slp = 1; step(); idle_inputs();
    for (int i = 0; i < 4; i++) begin stat_cmd = 1; step(); end
    idle_inputs();
    chk("R7 still sleeping", {14'd0, pwr}, 16'h0001);
    ack = 1; byte_rd = 1; step(); idle_inputs();
    for (int i = 0; i < WCYC; i++) step();

    // constrained random
    for (int blk = 0; blk < 20; blk++) begin
      two_wire = ($urandom_range(0, 1) == 1);
      for (int i = 0; i < 200; i++) begin
        idle_inputs();
        ack      = ($urandom_range(0, 3) != 0);
        byte_rd  = ($urandom_range(0, 2) == 0);
        stat_cmd = !byte_rd && ($urandom_range(0, 4) == 0);
        mem_data = 8'($urandom());
        mem_wr   = ($urandom_range(0, 7) == 0);
        if ($urandom_range(0, 9) == 0) begin
          ptr_load = 1;
          case ($urandom_range(0, 3))
            0, 1: ptr_addr = SADR;
            2:    ptr_addr = SADR - 16'($urandom_range(1, 2));
            default: ptr_addr = 16'($urandom());
          endcase
        end
        if ($urandom_range(0, 7) == 0) wip = ~wip;
        crc    = ($urandom_range(0, 1) == 1);
        rrdy   = ($urandom_range(0, 1) == 1);
        exec_e = ($urandom_range(0, 3) == 0);
        wset   = ($urandom_range(0, 9) == 0);
        wclr   = ($urandom_range(0, 9) == 0);
        slp    = ($urandom_range(0, 39) == 0);
        stb    = ($urandom_range(0, 39) == 0);
        chk_wr();
        step();
      end
    end
    idle_inputs();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule